// File: doc/BRIEF.md
# Transmit Descriptor DMA Run Controller

This block is the control state machine of a transmit DMA engine that works through a ring of descriptors held in memory. A software run bit starts and stops it. The block holds a current list position. It reads the descriptor at that position through a request/response port and examines the ownership bit. When the DMA owns the descriptor, the block issues a frame transfer request carrying the descriptor address. It then waits for the frame-complete pulse and moves to the next descriptor. When the DMA does not own the descriptor, the block parks in a suspended state and raises a sticky "no buffer available" flag.

Stopping is deferred. Clearing the run bit takes effect only when the frame in progress has finished, and at once when the block is suspended. The position of the next descriptor is kept, so the next start resumes from that point. Writing the ring base while stopped sets the position, so the first start after a base write begins at the base. Data movement and the MAC are outside this block.

The descriptor read request and the frame transfer request are valid/ready streams. Once valid is raised it stays high, with its address unchanged, until the cycle in which ready is high. A transfer happens on each cycle where both are high. The descriptor response has no back-pressure: the block accepts `rd_rsp_valid` on any cycle it waits for one and ignores it otherwise. Control and status pins are plain single-cycle strobes and levels.

Top module: `txdesc_run_ctrl`

## Requirements
- R1: In the Stopped state (`state_o` = 0), a write of 1 to the run bit (`run_wr` with `run_val` = 1) moves the block to Running (`state_o` = 1) on the next cycle. It then raises `rd_req_valid` with `rd_req_addr` equal to the current position.
- R2: A base write (`base_wr`) while Stopped loads `base_addr` into both the wrap target and the current position. A base write in any other state changes only the wrap target, and `cur_pos` stays the same.
- R3: A descriptor response whose bit OWN_BIT is 0 (owned by software) moves the block to Suspended (`state_o` = 2) on the next cycle and sets `no_buf_flag`. The position does not change.
- R4: A write of 1 to the run bit while Running has no effect. The block stays Running and issues no additional request.
- R5: A write of 0 to the run bit while a frame is in progress keeps the block Running until `frame_done`, then moves it to Stopped. In Suspended, the block moves to Stopped on the next cycle. If the stop is pending when a descriptor response arrives, the block stops without a transfer request.
- R6: On a stop, `cur_pos` holds the next descriptor position. The next start fetches from that position and not from the base. No request is made while Stopped.
- R7: A descriptor response whose bit OWN_BIT is 1 leads to a transfer request (`xfer_valid`) whose `xfer_addr` is the descriptor address. Both request streams hold valid and address stable until ready.
- R8: On `frame_done`, the position advances by DESC_BYTES. If the descriptor had bit EOR_BIT set (end of ring), the position returns to the wrap target instead.
- R9: In Suspended, a `poll_req` pulse or a write of 1 to the run bit starts a new fetch at the current position.
- R10: `no_buf_flag` stays set until a `no_buf_clr` pulse clears it. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_wr | input | 1 | Strobe: run bit written this cycle |
| run_val | input | 1 | Value written to the run bit |
| poll_req | input | 1 | Strobe: retry fetch when suspended |
| base_wr | input | 1 | Strobe: ring base written |
| base_addr | input | ADDR_W | Ring base value |
| no_buf_clr | input | 1 | Write-one-to-clear for `no_buf_flag` |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Descriptor read request ready |
| rd_req_addr | output | ADDR_W | Descriptor read address |
| rd_rsp_valid | input | 1 | Descriptor word valid |
| rd_rsp_data | input | DATA_W | Descriptor control word |
| xfer_valid | output | 1 | Frame transfer request valid |
| xfer_ready | input | 1 | Frame transfer request ready |
| xfer_addr | output | ADDR_W | Address of descriptor to send |
| frame_done | input | 1 | Strobe: current frame finished |
| state_o | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| cur_pos | output | ADDR_W | Current list position |
| no_buf_flag | output | 1 | Sticky buffer-unavailable status |

## Verification
The bench builds the block with ADDR_W = 12, DESC_BYTES = 16, OWN_BIT = 31 and EOR_BIT = 30. The narrow address keeps the ring in an eight-entry model memory. Placing the end-of-ring flag below the ownership bit shows that each field is decoded at its own position. The memory model hands ownership back on each transfer handshake, and both ready lines toggle. As a result, wrap-around, suspend on a returned descriptor, and request hold under back-pressure all occur within a short run. A held-off frame-complete lets the bench observe a deferred stop and a start write ignored while Running.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

  // internal controller phases
  typedef enum logic [2:0] {
    PH_IDLE,      // stopped
    PH_FETCH_REQ, // descriptor read offered
    PH_FETCH_WAIT,// waiting for descriptor word
    PH_XFER_REQ,  // transfer request offered
    PH_XFER_BUSY, // frame in flight
    PH_PARK       // suspended
  } phase_t;

  // externally visible state codes
  localparam logic [1:0] ST_STOPPED = 2'd0;
  localparam logic [1:0] ST_RUNNING = 2'd1;
  localparam logic [1:0] ST_SUSPEND = 2'd2;

  function automatic logic [1:0] phase_to_state(input phase_t p);
    case (p)
      PH_IDLE: return ST_STOPPED;
      PH_PARK: return ST_SUSPEND;
      default: return ST_RUNNING;
    endcase
  endfunction

endpackage

// File: rtl/txdesc_fsm.sv
module txdesc_fsm
  import txdesc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OWN_BIT = 31,
  parameter int EOR_BIT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_wr,
  input  logic              run_val,
  input  logic              poll_req,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              xfer_ready,
  input  logic              frame_done,
  output phase_t            phase,
  output logic              step_pos,
  output logic              wrap_pos,
  output logic              mark_unavail
);

  phase_t phase_q, phase_d;
  logic   run_q;
  logic   eor_q;
  logic   run_eff;
  logic   desc_own;
  logic   desc_eor;

  assign run_eff  = run_wr ? run_val : run_q;
  assign desc_own = rd_rsp_data[OWN_BIT];
  assign desc_eor = rd_rsp_data[EOR_BIT];

  always_comb begin
    phase_d      = phase_q;
    step_pos     = 1'b0;
    mark_unavail = 1'b0;
    case (phase_q)
      PH_IDLE:
        if (run_wr && run_val) phase_d = PH_FETCH_REQ;
      PH_FETCH_REQ:
        if (rd_req_ready) phase_d = PH_FETCH_WAIT;
      PH_FETCH_WAIT:
        if (rd_rsp_valid) begin
          if (!run_eff) begin
            phase_d = PH_IDLE;
          end else if (!desc_own) begin
            phase_d      = PH_PARK;
            mark_unavail = 1'b1;
          end else begin
            phase_d = PH_XFER_REQ;
          end
        end
      PH_XFER_REQ:
        if (xfer_ready) phase_d = PH_XFER_BUSY;
      PH_XFER_BUSY:
        if (frame_done) begin
          step_pos = 1'b1;
          phase_d  = run_eff ? PH_FETCH_REQ : PH_IDLE;
        end
      PH_PARK:
        if (!run_eff) phase_d = PH_IDLE;
        else if (poll_req || (run_wr && run_val)) phase_d = PH_FETCH_REQ;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      run_q   <= 1'b0;
      eor_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      run_q   <= run_eff;
      if (phase_q == PH_FETCH_WAIT && rd_rsp_valid) eor_q <= desc_eor;
    end
  end

  assign phase    = phase_q;
  assign wrap_pos = eor_q;

endmodule

// File: rtl/txdesc_pos.sv
module txdesc_pos #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              stopped,
  input  logic              step_pos,
  input  logic              wrap_pos,
  output logic [ADDR_W-1:0] pos
);

  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
    end else begin
      if (base_wr) base_q <= base_addr;
      if (base_wr && stopped) pos_q <= base_addr;
      else if (step_pos) pos_q <= wrap_pos ? base_q : pos_q + STRIDE;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/txdesc_flag.sv
module txdesc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/txdesc_run_ctrl.sv
module txdesc_run_ctrl
  import txdesc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int OWN_BIT    = 31,
  parameter int EOR_BIT    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_wr,
  input  logic              run_val,
  input  logic              poll_req,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              no_buf_clr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  input  logic              frame_done,
  output logic [1:0]        state_o,
  output logic [ADDR_W-1:0] cur_pos,
  output logic              no_buf_flag
);

  phase_t phase;
  logic   step_pos;
  logic   wrap_pos;
  logic   mark_unavail;

  txdesc_fsm #(
    .DATA_W (DATA_W),
    .OWN_BIT(OWN_BIT),
    .EOR_BIT(EOR_BIT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_wr      (run_wr),
    .run_val     (run_val),
    .poll_req    (poll_req),
    .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data (rd_rsp_data),
    .xfer_ready  (xfer_ready),
    .frame_done  (frame_done),
    .phase       (phase),
    .step_pos    (step_pos),
    .wrap_pos    (wrap_pos),
    .mark_unavail(mark_unavail)
  );

  txdesc_pos #(
    .ADDR_W    (ADDR_W),
    .DESC_BYTES(DESC_BYTES)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_wr  (base_wr),
    .base_addr(base_addr),
    .stopped  (phase == PH_IDLE),
    .step_pos (step_pos),
    .wrap_pos (wrap_pos),
    .pos      (cur_pos)
  );

  txdesc_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (mark_unavail),
    .clr_i (no_buf_clr),
    .flag_o(no_buf_flag)
  );

  assign rd_req_valid = (phase == PH_FETCH_REQ);
  assign rd_req_addr  = cur_pos;
  assign xfer_valid   = (phase == PH_XFER_REQ);
  assign xfer_addr    = cur_pos;
  assign state_o      = phase_to_state(phase);

endmodule

// File: rtl/txdesc_run_chk.sv
module txdesc_run_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OWN_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_wr,
  input logic              run_val,
  input logic              base_wr,
  input logic              no_buf_clr,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic [DATA_W-1:0] rd_rsp_data,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [1:0]        state_o,
  input logic [ADDR_W-1:0] cur_pos,
  input logic              no_buf_flag
);

  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd0 |-> !rd_req_valid && !xfer_valid);

  assert_stopped_pos_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd0 && !base_wr |=> cur_pos == $past(cur_pos));

  assert_not_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd1 && rd_rsp_valid && !rd_rsp_data[OWN_BIT] && !rd_req_valid && !xfer_valid
      |=> state_o != 2'd1 && (state_o == 2'd0 || no_buf_flag));

  assert_run_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd1 && run_wr && run_val |=> state_o != 2'd0);

  assert_park_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd2 && run_wr && !run_val |=> state_o == 2'd0);

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_xfer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf_flag && !no_buf_clr |=> no_buf_flag);

endmodule

bind txdesc_run_ctrl txdesc_run_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OWN_BIT(OWN_BIT)
) i_chk (.*);

// File: tb/test_txdesc_run_ctrl.sv
module test_txdesc_run_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int OWN = 31;
  localparam int EOR = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_wr = 1'b0, run_val = 1'b0, poll_req = 1'b0;
  logic          base_wr = 1'b0, no_buf_clr = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          rd_req_valid, xfer_valid, no_buf_flag;
  logic          rd_req_ready = 1'b0, xfer_ready = 1'b0;
  logic [AW-1:0] rd_req_addr, xfer_addr, cur_pos;
  logic          rd_rsp_valid = 1'b0;
  logic [DW-1:0] rd_rsp_data = '0;
  logic          frame_done = 1'b0;
  logic [1:0]    state_o;

  int total = 0, bad = 0;
  logic [DW-1:0] mem [8];
  logic [AW:0]   expq[$];   // {kind(1=xfer), addr}
  bit            hold_done = 1'b0;
  int            done_cnt = 0;
  int            cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdesc_run_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DESC_BYTES(16),
                    .OWN_BIT(OWN), .EOR_BIT(EOR)) i_txdesc_run_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input bit kind, input logic [AW-1:0] a);
    expq.push_back({kind, a});
  endtask

  // memory model, ready toggling, frame completion and scoreboard monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_req_ready <= cyc[0];
    xfer_ready   <= cyc[1];
    rd_rsp_valid <= 1'b0;
    if (rst_n && rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[6:4]];
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected read actual=%0h expected=none", rd_req_addr);
      end else begin
        logic [AW:0] e;
        e = expq.pop_front();
        if (e !== {1'b0, rd_req_addr}) begin
          bad++;
          $display("FAIL R1 read actual=%0h expected=%0h", {1'b0, rd_req_addr}, e);
        end
      end
    end
    if (rst_n && xfer_valid && xfer_ready) begin
      mem[xfer_addr[6:4]][OWN] <= 1'b0;
      done_cnt <= 3;
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected xfer actual=%0h expected=none", xfer_addr);
      end else begin
        logic [AW:0] e;
        e = expq.pop_front();
        if (e !== {1'b1, xfer_addr}) begin
          bad++;
          $display("FAIL R7 xfer actual=%0h expected=%0h", {1'b1, xfer_addr}, e);
        end
      end
    end else if (done_cnt > 1) begin
      done_cnt <= done_cnt - 1;
    end else if (done_cnt == 1 && !hold_done) begin
      done_cnt <= 0;
    end
    frame_done <= (done_cnt == 1 && !hold_done);
  end

  task automatic pulse_run(input logic v);
    @(negedge clk); run_wr = 1'b1; run_val = v;
    @(negedge clk); run_wr = 1'b0;
  endtask

  task automatic pulse_base(input logic [AW-1:0] a);
    @(negedge clk); base_wr = 1'b1; base_addr = a;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic wait_state(input logic [1:0] s);
    do @(negedge clk); while (state_o !== s);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // reset state
    check("R1 reset state", state_o, 0);
    check("R6 reset quiet", {rd_req_valid, xfer_valid}, 0);
    check("R10 reset flag", no_buf_flag, 0);
    rst_n = 1'b1;

    // R2: base write while stopped sets position
    pulse_base(12'h100);
    check("R2 base loads pos", cur_pos, 12'h100);

    // ring of two: 0x100 owned, 0x110 owned + end of ring
    mem[0] = 32'h8000_0000;
    mem[1] = 32'hC000_0000;
    expect_item(0, 12'h100); expect_item(1, 12'h100);
    expect_item(0, 12'h110); expect_item(1, 12'h110);
    expect_item(0, 12'h100);
    pulse_run(1'b1);
    check("R1 running after start", state_o, 1);
    wait_state(2);
    check("R3 suspended flag", no_buf_flag, 1);
    check("R8 wrap to base", cur_pos, 12'h100);
    check("R8 scoreboard drained", expq.size(), 0);

    // R9: poll retries from suspended
    mem[0] = 32'h8000_0000;
    expect_item(0, 12'h100); expect_item(1, 12'h100); expect_item(0, 12'h110);
    @(negedge clk); poll_req = 1'b1; @(negedge clk); poll_req = 1'b0;
    check("R9 poll leaves suspend", state_o, 1);
    wait_state(2);
    check("R8 advance by stride", cur_pos, 12'h110);
    check("R10 flag sticky", no_buf_flag, 1);
    @(negedge clk); no_buf_clr = 1'b1; @(negedge clk); no_buf_clr = 1'b0;
    check("R10 flag cleared", no_buf_flag, 0);

    // R2: base write when not stopped leaves position alone
    pulse_base(12'h300);
    check("R2 base ignored for pos", cur_pos, 12'h110);
    pulse_base(12'h100);

    // R5: stop from suspended is immediate
    pulse_run(1'b0);
    check("R5 suspend stops at once", state_o, 0);
    check("R6 pos saved on stop", cur_pos, 12'h110);

    // R6 restart from saved position, R5 deferred stop, R4 ignored start
    mem[1] = 32'hC000_0000;
    hold_done = 1'b1;
    expect_item(0, 12'h110); expect_item(1, 12'h110);
    pulse_run(1'b1);
    while (expq.size() != 0) @(negedge clk);
    idle(4);
    pulse_run(1'b0);
    idle(3);
    check("R5 stop deferred", state_o, 1);
    pulse_run(1'b1);
    pulse_run(1'b0);
    check("R4 start while running", state_o, 1);
    hold_done = 1'b0;
    wait_state(0);
    idle(4);
    check("R5 stopped after frame", state_o, 0);
    check("R8 eor wrap on stop", cur_pos, 12'h100);
    check("R4 no extra requests", expq.size(), 0);

    // R6: restart resumes at saved 0x100
    mem[0] = 32'h8000_0000;
    expect_item(0, 12'h100); expect_item(1, 12'h100); expect_item(0, 12'h110);
    pulse_run(1'b1);
    wait_state(2);
    check("R6 resumed and suspended", cur_pos, 12'h110);
    check("R3 flag again", no_buf_flag, 1);

    // R10: set and clear in the same cycle keeps flag
    pulse_run(1'b0);
    @(negedge clk); no_buf_clr = 1'b1; @(negedge clk); no_buf_clr = 1'b0;
    pulse_base(12'h200);
    check("R2 new base after stop", cur_pos, 12'h200);
    expect_item(0, 12'h200);
    pulse_run(1'b1);
    do @(negedge clk); while (!(rd_rsp_valid));
    no_buf_clr = 1'b1;
    @(negedge clk); no_buf_clr = 1'b0;
    check("R10 set wins over clear", no_buf_flag, 1);
    check("R3 suspend on not owned", state_o, 2);
    check("R3 pos unchanged", cur_pos, 12'h200);
    check("R7 scoreboard empty", expq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule